// File: doc/BRIEF.md
# Platform Sleep State Sequencer

This block moves a platform between its working state, the sleep depths S1, S3, S4 and S5, and a mechanical-off condition in which main power is absent. Software starts a sleep by writing a sleep-type code while the platform is working. The block then walks six active-low controls through a fixed ladder. First comes the processor stop request, then the suspend-status flag, then platform reset, and last the three graded sleep-rail enables. Each step is separated by a programmable number of clock cycles. A wake event walks the same ladder back down in reverse order.

Power loss forces every control low at once. When main power returns, a configuration bit decides the outcome. With the bit set, the platform stays in soft off (S5), where a small always-on part still accepts wake events. With the bit clear, the platform climbs back to the working state. A wake that arrives while an entry sequence is still running is remembered. It turns the block around as soon as the target depth is reached. The processor handshake is reduced to a request output and a grant input.

States: `ST_OFF` (mechanical off), `ST_ON` (working), entry states `EN_STOP`, `EN_SUSP`, `EN_RST`, `EN_R3`, `EN_R4`, `EN_R5`, the resting state `ST_SLP`, and exit states `EX_R5`, `EX_R4`, `EX_R3`, `EX_RST`, `EX_SUSP`.

Transitions:
- `ST_OFF` goes to `ST_SLP` (stay_off = 1) or to `EX_R5` (stay_off = 0) once power is present.
- `ST_ON` goes to `EN_STOP` on an accepted write.
- `EN_STOP` goes to `EN_SUSP`, or to `ST_SLP` for S1, when the grant is high and the dwell has elapsed.
- `EN_SUSP` goes to `EN_RST`, and `EN_RST` goes to `EN_R3`.
- `EN_R3` goes to `ST_SLP` for S3, otherwise to `EN_R4`. `EN_R4` goes to `ST_SLP` for S4, otherwise to `EN_R5`. `EN_R5` goes to `ST_SLP`.
- `ST_SLP` goes to `ST_ON`, `EX_R3`, `EX_R4` or `EX_R5`, according to depth, on a wake or a latched wake.
- The exit states run `EX_R5`, then `EX_R4`, `EX_R3`, `EX_RST`, `EX_SUSP`, and finally `ST_ON`.
- Any state goes to `ST_OFF` when power is absent.

Top module: `sleep_seq_top`

## Requirements
- R1: While rst_n is low, and one clock edge after entering mechanical off, all six outputs (stop_req_n, susp_stat_n, plat_rst_n, rail_s3_n, rail_s4_n, rail_s5_n) are low.
- R2: A write (typ_wr high) is accepted only in the working state (all outputs high). typ_val 3'd1, 3'd3, 3'd4 and 3'd5 select S1, S3, S4 and S5. Codes 3'd0, 3'd2 (S2, unsupported), 3'd6 and 3'd7 are ignored, as is any write outside the working state.
- R3: Entry begins by driving stop_req_n low one edge after the write. susp_stat_n does not fall until stop_ack has been sampled high.
- R4: After the stop step, entry lowers susp_stat_n, plat_rst_n, rail_s3_n, rail_s4_n and rail_s5_n in that order, stopping at the rail of the target depth. S1 lowers only stop_req_n. Successive changes are max(step_dly,1) cycles apart, and the outputs then hold.
- R5: Exit raises the lowered outputs in exactly the reverse order, with the same spacing, and ends with all outputs high.
- R6: A wake while resting at any depth, soft off included, makes the first exit change on the next clock edge.
- R7: A wake seen during entry is latched. Two edges after the target rail falls, exit begins without a further wake.
- R8: When power returns, stay_off = 1 keeps all outputs low until a wake. stay_off = 0 starts the exit sequence on the next edge.
- R9: pwr_ok low in any state drives all outputs low on the next edge.
- R10: The outputs are always nested. Each control in the order stop, suspend, reset, rail S3, rail S4, rail S5 can be low only if the one before it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Main power present |
| stay_off | input | 1 | After power returns: 1 stay in soft off, 0 power up |
| typ_wr | input | 1 | Sleep-type write strobe |
| typ_val | input | 3 | Sleep-type code |
| wake | input | 1 | Wake event |
| step_dly | input | DLY_W | Cycles between successive output changes (0 acts as 1) |
| stop_ack | input | 1 | Processor stop grant |
| stop_req_n | output | 1 | Processor stop request, active low |
| susp_stat_n | output | 1 | Suspend status, active low |
| plat_rst_n | output | 1 | Platform reset, active low |
| rail_s3_n | output | 1 | S3 sleep-rail control, active low |
| rail_s4_n | output | 1 | S4 sleep-rail control, active low |
| rail_s5_n | output | 1 | S5 sleep-rail control, active low |

## Verification
The assertions check four things on every cycle: the nesting of the six controls, the all-low response to lost power, that no more than one control moves per edge while power is present, and that the suspend flag never falls without a prior grant. An unsupported or invalid code written while working is also checked every cycle, to confirm it never starts an entry. Only the directed scenarios can show the exact spacing against step_dly and the depth at which entry stops. They also cover the reverse exit order, the turnaround of a wake latched mid-entry, and the choice made by stay_off when power returns.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int unsigned TYP_W   = 3;
    localparam int unsigned NUM_CTL = 6;

    localparam logic [TYP_W-1:0] TYP_S1 = 3'd1;
    localparam logic [TYP_W-1:0] TYP_S3 = 3'd3;
    localparam logic [TYP_W-1:0] TYP_S4 = 3'd4;
    localparam logic [TYP_W-1:0] TYP_S5 = 3'd5;

    typedef enum logic [1:0] {
        DP_S1,
        DP_S3,
        DP_S4,
        DP_S5
    } depth_e;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_ON,
        EN_STOP,
        EN_SUSP,
        EN_RST,
        EN_R3,
        EN_R4,
        EN_R5,
        ST_SLP,
        EX_R5,
        EX_R4,
        EX_R3,
        EX_RST,
        EX_SUSP
    } seq_state_e;

    // Ladder level n means the first n controls (stop first) are asserted.
    // The returned vector is active low, ordered {stop, susp, rst, r3, r4, r5}.
    function automatic logic [NUM_CTL-1:0] level_to_ctl(input int unsigned lvl);
        logic [NUM_CTL-1:0] v;
        for (int unsigned i = 0; i < NUM_CTL; i++) begin
            v[NUM_CTL-1-i] = !(lvl > i);
        end
        return v;
    endfunction

endpackage

// File: rtl/slp_step_timer.sv
module slp_step_timer #(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DLY_W-1:0] dly,
    output logic             done
);

    logic [DLY_W-1:0] cnt;
    logic [DLY_W:0]   cnt_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != {DLY_W{1'b1}}) begin
            cnt <= cnt + {{(DLY_W-1){1'b0}}, 1'b1};
        end
    end

    // The state has been held cnt+1 cycles; a delay of zero acts as one.
    always_comb begin
        cnt_next = {1'b0, cnt} + {{DLY_W{1'b0}}, 1'b1};
        done     = (cnt_next >= {1'b0, dly});
    end

endmodule

// File: rtl/slp_req_decode.sv
module slp_req_decode
    import slp_pkg::*;
(
    input  logic             typ_wr,
    input  logic [TYP_W-1:0] typ_val,
    output logic             req_ok,
    output depth_e           req_depth
);

    always_comb begin
        req_ok    = 1'b0;
        req_depth = DP_S5;
        case (typ_val)
            TYP_S1: begin req_ok = typ_wr; req_depth = DP_S1; end
            TYP_S3: begin req_ok = typ_wr; req_depth = DP_S3; end
            TYP_S4: begin req_ok = typ_wr; req_depth = DP_S4; end
            TYP_S5: begin req_ok = typ_wr; req_depth = DP_S5; end
            default: begin req_ok = 1'b0; req_depth = DP_S5; end
        endcase
    end

endmodule

// File: rtl/slp_wake_latch.sv
module slp_wake_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic set_en,
    input  logic clr,
    output logic pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (set_en && wake) begin
            pend <= 1'b1;
        end else if (clr) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_ok,
    input  logic               stay_off,
    input  logic               req_ok,
    input  depth_e             req_depth,
    input  logic               wake,
    input  logic               wake_pend,
    input  logic               stop_ack,
    input  logic               step_done,
    output logic               restart,
    output logic               in_entry,
    output logic               clr_pend,
    output logic [NUM_CTL-1:0] ctl
);

    seq_state_e  state, nxt;
    depth_e      depth;
    int unsigned lvl;
    logic        go_up;

    assign go_up = wake || wake_pend;

    // next-state logic
    always_comb begin
        nxt = state;
        if (!pwr_ok) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  nxt = stay_off ? ST_SLP : EX_R5;
                ST_ON:   if (req_ok) nxt = EN_STOP;
                EN_STOP: if (stop_ack && step_done)
                             nxt = (depth == DP_S1) ? ST_SLP : EN_SUSP;
                EN_SUSP: if (step_done) nxt = EN_RST;
                EN_RST:  if (step_done) nxt = EN_R3;
                EN_R3: begin
                    if (depth == DP_S3)  nxt = ST_SLP;
                    else if (step_done)  nxt = EN_R4;
                end
                EN_R4: begin
                    if (depth == DP_S4)  nxt = ST_SLP;
                    else if (step_done)  nxt = EN_R5;
                end
                EN_R5:   nxt = ST_SLP;
                ST_SLP: begin
                    if (go_up) begin
                        unique case (depth)
                            DP_S1: nxt = ST_ON;
                            DP_S3: nxt = EX_R3;
                            DP_S4: nxt = EX_R4;
                            DP_S5: nxt = EX_R5;
                            default: nxt = EX_R5;
                        endcase
                    end
                end
                EX_R5:   if (step_done) nxt = EX_R4;
                EX_R4:   if (step_done) nxt = EX_R3;
                EX_R3:   if (step_done) nxt = EX_RST;
                EX_RST:  if (step_done) nxt = EX_SUSP;
                EX_SUSP: if (step_done) nxt = ST_ON;
                default: nxt = ST_OFF;
            endcase
        end
    end

    // state register with captured depth
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            depth <= DP_S5;
        end else begin
            state <= nxt;
            if (state == ST_OFF) begin
                depth <= DP_S5;
            end else if (state == ST_ON && req_ok && pwr_ok) begin
                depth <= req_depth;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        in_entry = 1'b0;
        clr_pend = 1'b0;
        lvl      = 0;
        unique case (state)
            ST_OFF:  begin lvl = 6; clr_pend = 1'b1; end
            ST_ON:   begin lvl = 0; clr_pend = 1'b1; end
            EN_STOP: begin lvl = 1; in_entry = 1'b1; end
            EN_SUSP: begin lvl = 2; in_entry = 1'b1; end
            EN_RST:  begin lvl = 3; in_entry = 1'b1; end
            EN_R3:   begin lvl = 4; in_entry = 1'b1; end
            EN_R4:   begin lvl = 5; in_entry = 1'b1; end
            EN_R5:   begin lvl = 6; in_entry = 1'b1; end
            ST_SLP: begin
                unique case (depth)
                    DP_S1: lvl = 1;
                    DP_S3: lvl = 4;
                    DP_S4: lvl = 5;
                    DP_S5: lvl = 6;
                    default: lvl = 6;
                endcase
            end
            EX_R5:   begin lvl = 5; clr_pend = 1'b1; end
            EX_R4:   begin lvl = 4; clr_pend = 1'b1; end
            EX_R3:   begin lvl = 3; clr_pend = 1'b1; end
            EX_RST:  begin lvl = 2; clr_pend = 1'b1; end
            EX_SUSP: begin lvl = 1; clr_pend = 1'b1; end
            default: begin lvl = 6; clr_pend = 1'b1; end
        endcase
        ctl     = level_to_ctl(lvl);
        restart = (nxt != state);
    end

endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
    import slp_pkg::*;
#(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok,
    input  logic             stay_off,
    input  logic             typ_wr,
    input  logic [2:0]       typ_val,
    input  logic             wake,
    input  logic [DLY_W-1:0] step_dly,
    input  logic             stop_ack,
    output logic             stop_req_n,
    output logic             susp_stat_n,
    output logic             plat_rst_n,
    output logic             rail_s3_n,
    output logic             rail_s4_n,
    output logic             rail_s5_n
);

    logic               req_ok;
    depth_e             req_depth;
    logic               wake_pend;
    logic               step_done;
    logic               restart;
    logic               in_entry;
    logic               clr_pend;
    logic [NUM_CTL-1:0] ctl;

    slp_req_decode u_dec (
        .typ_wr    (typ_wr),
        .typ_val   (typ_val),
        .req_ok    (req_ok),
        .req_depth (req_depth)
    );

    slp_step_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .dly     (step_dly),
        .done    (step_done)
    );

    slp_wake_latch u_wk (
        .clk    (clk),
        .rst_n  (rst_n),
        .wake   (wake),
        .set_en (in_entry),
        .clr    (clr_pend),
        .pend   (wake_pend)
    );

    slp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .stay_off  (stay_off),
        .req_ok    (req_ok),
        .req_depth (req_depth),
        .wake      (wake),
        .wake_pend (wake_pend),
        .stop_ack  (stop_ack),
        .step_done (step_done),
        .restart   (restart),
        .in_entry  (in_entry),
        .clr_pend  (clr_pend),
        .ctl       (ctl)
    );

    assign {stop_req_n, susp_stat_n, plat_rst_n, rail_s3_n, rail_s4_n, rail_s5_n} = ctl;

endmodule

// File: rtl/slp_seq_chk.sv
module slp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_ok,
    input logic       typ_wr,
    input logic [2:0] typ_val,
    input logic       stop_ack,
    input logic       stop_req_n,
    input logic       susp_stat_n,
    input logic       plat_rst_n,
    input logic       rail_s3_n,
    input logic       rail_s4_n,
    input logic       rail_s5_n
);

    logic [5:0] c;
    assign c = {stop_req_n, susp_stat_n, plat_rst_n, rail_s3_n, rail_s4_n, rail_s5_n};

    // R10
    nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!susp_stat_n -> !stop_req_n) && (!plat_rst_n -> !susp_stat_n) &&
        (!rail_s3_n -> !plat_rst_n) && (!rail_s4_n -> !rail_s3_n) &&
        (!rail_s5_n -> !rail_s4_n));

    // R9
    pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (c == 6'b000000));

    // R3
    stop_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(susp_stat_n) && $past(pwr_ok)) |-> $past(stop_ack));

    // R4
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_ok) |-> ($countones(c ^ $past(c)) <= 1));

    // R2
    bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && c == 6'b111111 && typ_wr &&
         (typ_val == 3'd0 || typ_val == 3'd2 || typ_val > 3'd5)) |=> stop_req_n);

endmodule

bind sleep_seq_top slp_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_ok      (pwr_ok),
    .typ_wr      (typ_wr),
    .typ_val     (typ_val),
    .stop_ack    (stop_ack),
    .stop_req_n  (stop_req_n),
    .susp_stat_n (susp_stat_n),
    .plat_rst_n  (plat_rst_n),
    .rail_s3_n   (rail_s3_n),
    .rail_s4_n   (rail_s4_n),
    .rail_s5_n   (rail_s5_n)
);

// File: tb/tb_sleep_seq_top.sv
module tb_sleep_seq_top;

    localparam int DLY_W = 8;

    logic             clk = 1'b0;
    logic             rst_n, pwr_ok, stay_off, typ_wr, wake, stop_ack;
    logic [2:0]       typ_val;
    logic [DLY_W-1:0] step_dly;
    logic             stop_req_n, susp_stat_n, plat_rst_n, rail_s3_n, rail_s4_n, rail_s5_n;
    logic [5:0]       outv;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sleep_seq_top #(.DLY_W(DLY_W)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .stay_off(stay_off),
        .typ_wr(typ_wr), .typ_val(typ_val), .wake(wake), .step_dly(step_dly),
        .stop_ack(stop_ack), .stop_req_n(stop_req_n), .susp_stat_n(susp_stat_n),
        .plat_rst_n(plat_rst_n), .rail_s3_n(rail_s3_n), .rail_s4_n(rail_s4_n),
        .rail_s5_n(rail_s5_n)
    );

    assign outv = {stop_req_n, susp_stat_n, plat_rst_n, rail_s3_n, rail_s4_n, rail_s5_n};

    // Expected vector for n asserted controls, stop first, active low.
    function automatic logic [5:0] lv(input int n);
        logic [5:0] v;
        for (int i = 0; i < 6; i++) v[5-i] = (i >= n);
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step_to(input logic [5:0] exp, input int gap, input string tag);
        logic [5:0] prev;
        int n;
        prev = outv;
        n = 0;
        do begin
            @(negedge clk);
            typ_wr = 1'b0;
            wake   = 1'b0;
            n++;
        end while (outv == prev && n < 64);
        chk(outv == exp, tag, outv, exp);
        if (gap >= 0) begin
            checks++;
            if (n != gap) begin
                errors++;
                $display("FAIL %s spacing: got %0d cycles expected %0d", tag, n, gap);
            end
        end
    endtask

    task automatic hold(input logic [5:0] exp, input int cyc, input string tag);
        bit ok;
        logic [5:0] bad;
        ok = 1'b1;
        bad = exp;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            typ_wr = 1'b0;
            wake   = 1'b0;
            if (outv != exp && ok) begin ok = 1'b0; bad = outv; end
        end
        chk(ok, tag, bad, exp);
    endtask

    task automatic walk(input int a, input int b, input int g1, input int g, input string tag);
        int l;
        bit first;
        l = a;
        first = 1'b1;
        while (l != b) begin
            l += (b > a) ? 1 : -1;
            step_to(lv(l), first ? g1 : g, tag);
            first = 1'b0;
        end
    endtask

    task automatic write_type(input logic [2:0] v);
        typ_val = v;
        typ_wr  = 1'b1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; pwr_ok = 1'b0; stay_off = 1'b0; typ_wr = 1'b0; typ_val = 3'd0;
        wake = 1'b0; stop_ack = 1'b1; step_dly = 8'd4;
        repeat (3) @(negedge clk);
        chk(outv == lv(6), "R1 reset", outv, lv(6));
        rst_n = 1'b1;
        hold(lv(6), 5, "R1 mech off");
    endtask

    task automatic t_power_up_on;
        stay_off = 1'b0;
        pwr_ok   = 1'b1;
        walk(6, 0, 1, 4, "R8 power-up R5 order");
    endtask

    task automatic t_bad_types;
        logic [2:0] codes [4];
        codes = '{3'd0, 3'd2, 3'd6, 3'd7};
        for (int i = 0; i < 4; i++) begin
            write_type(codes[i]);
            hold(lv(0), 8, "R2 invalid code");
        end
    endtask

    task automatic t_s1;
        write_type(3'd1);
        step_to(lv(1), 1, "R3 S1 stop");
        hold(lv(1), 12, "R4 S1 only stop");
        wake = 1'b1;
        step_to(lv(0), 1, "R6 S1 wake");
    endtask

    task automatic t_s3_late_ack;
        stop_ack = 1'b0;
        write_type(3'd3);
        step_to(lv(1), 1, "R3 stop first");
        hold(lv(1), 12, "R3 wait grant");
        stop_ack = 1'b1;
        walk(1, 4, 1, 4, "R4,R10 S3 entry");
        hold(lv(4), 10, "R4 S3 rest");
        wake = 1'b1;
        walk(4, 0, 1, 4, "R5 S3 exit");
    endtask

    task automatic t_s5;
        step_dly = 8'd2;
        write_type(3'd5);
        walk(0, 6, 1, 2, "R4,R10 S5 entry");
        hold(lv(6), 6, "R4 S5 rest");
        wake = 1'b1;
        walk(6, 0, 1, 2, "R6 soft-off wake");
    endtask

    task automatic t_s4_fast;
        step_dly = 8'd0;
        write_type(3'd4);
        walk(0, 5, 1, 1, "R4 zero delay");
        hold(lv(5), 4, "R4 S4 rest");
        wake = 1'b1;
        walk(5, 0, 1, 1, "R5 zero delay");
    endtask

    task automatic t_wake_in_entry;
        step_dly = 8'd4;
        write_type(3'd4);
        step_to(lv(1), 1, "R7 entry start");
        wake = 1'b1;
        write_type(3'd5);       // ignored: not in working state (R2)
        step_to(lv(2), 4, "R7 entry continues");
        step_to(lv(3), 4, "R7 entry continues");
        step_to(lv(4), 4, "R7 entry continues");
        step_to(lv(5), 4, "R2 depth kept S4");
        step_to(lv(4), 2, "R7 latched turnaround");
        walk(4, 0, 4, 4, "R7 exit");
    endtask

    task automatic t_loss_sleep;
        step_dly = 8'd4;
        write_type(3'd3);
        walk(0, 4, 1, 4, "R4 S3 entry");
        pwr_ok = 1'b0;
        step_to(lv(6), 1, "R9 loss in sleep");
        stay_off = 1'b1;
        pwr_ok   = 1'b1;
        hold(lv(6), 10, "R8 stay off");
        wake = 1'b1;
        walk(6, 0, 1, 4, "R8 wake from soft off");
    endtask

    task automatic t_loss_working;
        pwr_ok = 1'b0;
        step_to(lv(6), 1, "R9 loss while working");
        hold(lv(6), 3, "R1 mech off held");
        stay_off = 1'b0;
        pwr_ok   = 1'b1;
        walk(6, 0, 1, 4, "R8 auto power-up");
    endtask

    initial begin
        t_reset();
        t_power_up_on();
        t_bad_types();
        t_s1();
        t_s3_late_ack();
        t_s5();
        t_s4_fast();
        t_wake_in_entry();
        t_loss_sleep();
        t_loss_working();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule